// File: doc/BRIEF.md
# Write-Only I2C Configuration Register Slave

This block is the configuration store of a monitor video processor. It sits on a two-wire I2C bus as a target that only accepts writes. A transfer addresses the device, names one register by a subaddress byte and delivers exactly one data byte. The block checks the value, stores it and drives every control field out of the register file as parallel signals, ready for the video datapath.

SCL and SDA pass through a two-flop synchronizer into the system clock domain. START and STOP conditions are taken from SDA edges while SCL is high. The block acknowledges by pulling SDA low through `sda_oe_o`, which an open-drain pad turns into a bus drive. The register file returns to its default contents on the asynchronous reset. Contrast and per-channel gain never show their two forbidden 7-bit codes. Every accepted update produces a one-cycle commit strobe.

Top module: `vpc_cfg_i2c`

## Requirements
- R1: After reset the stored bytes at subaddresses 01h..10h are 80h,80h,80h,80h,80h,01h,09h,04h,10h,80h,80h,80h,08h,00h,00h,00h.
- R2: Only the 8-bit address byte DCh (write direction) is acknowledged. Any other address byte, including the read form DDh, gets no ACK, and the rest of that transfer is neither acknowledged nor stored.
- R3: A transfer stores only its first data byte, to the named subaddress. Later data bytes in the same transfer are not acknowledged, change no register and the subaddress does not advance.
- R4: Contrast (01h) and gains 1..3 (03h..05h) carry a 7-bit level in bits [7:1]. A written level of 00h is stored as 01h and a level of 7Fh is stored as 7Eh, so the outputs never show 00h or 7Fh.
- R5: A write changes only the addressed register. Reserved bits are stored as 0: bit 0 of 01h/03h..05h, bits 7:2 of 06h, bits 7:4 of 07h, bits 5 and 3 of 09h.
- R6: In register 08h, bit 7 drives `oclamp_sel_o`, bits 6:5 drive `factory_test_o[2:1]`, bit 4 drives `trig_src_o[1]`, bits 3:2 drive `clamp_width_o`, bit 1 drives `trig_edge_o` and bit 0 drives `trig_src_o[0]`.
- R7: In register 09h, bit 0 drives `blk_invert_o`, bit 1 `sw_blank_o`, bit 2 `ac_mode_o` (0 = DC, 1 = AC), bit 4 `factory_test_o[0]`, bit 6 `amp_blank_en_o` and bit 7 `amp_standby_o`.
- R8: A write to a subaddress outside 01h..10h is acknowledged on all three bytes but changes nothing and raises no commit.
- R9: `commit_o` pulses high for exactly one cycle per stored data byte, in the cycle the new value appears, during the data byte's ACK bit. It stays low at all other times.
- R10: `sda_oe_o` goes high only while SCL is low, lasts only over the ACK bit, and is low between transfers and after a STOP. A repeated START restarts address decoding.
- R11: Transfers are handled correctly for SCL high and low phases from 4 system clock cycles up to those of a 200 kHz bus at a 100 MHz clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| scl_i | input | 1 | I2C clock from the pad |
| sda_i | input | 1 | I2C data from the pad |
| sda_oe_o | output | 1 | High pulls SDA low (ACK) |
| commit_o | output | 1 | One-cycle strobe on each stored update |
| contrast_o | output | 7 | Video contrast level (01h[7:1]) |
| bright_o | output | 8 | Brightness code (02h) |
| gain_o | output | 3x7 | Per-channel gain, index 0 = channel 1 (03h..05h [7:1]) |
| bright_range_o | output | 2 | Brightness range (06h[1:0]) |
| osd_level_o | output | 4 | OSD contrast (07h[3:0]) |
| oclamp_sel_o | output | 1 | Output clamp source select (08h[7]) |
| trig_src_o | output | 2 | Input clamp source {08h[4], 08h[0]} |
| clamp_width_o | output | 2 | Input clamp width code (08h[3:2]) |
| trig_edge_o | output | 1 | Clamp trigger edge (08h[1]) |
| factory_test_o | output | 3 | Test bits {08h[6:5], 09h[4]} |
| blk_invert_o | output | 1 | Blanking input inversion (09h[0]) |
| sw_blank_o | output | 1 | Software blanking (09h[1]) |
| ac_mode_o | output | 1 | Cathode coupling, 1 = AC (09h[2]) |
| amp_blank_en_o | output | 1 | Amplifier blanking enable (09h[6]) |
| amp_standby_o | output | 1 | Amplifier standby (09h[7]) |
| cutoff_o | output | 3x8 | Per-channel cut-off level (0Ah..0Ch) |
| aux_o | output | 4x8 | Registers 0Dh..10h as stored |

## Verification
The assertions check on every cycle that the commit strobe is one cycle wide, that no more than one commit falls in a transfer, that the stored register bytes never move without a commit, that contrast and gains never show a forbidden level, and that the ACK drive rises only with SCL low and is dropped after a STOP. The bench scenarios cover the rest. They show which address bytes get an ACK, where every field lands, how levels are clamped, that unused subaddresses and extra data bytes are discarded, that a repeated START restarts decoding, and that the block works at both the slowest and the fastest SCL timing.

// File: rtl/vpc_cfg_pkg.sv
package vpc_cfg_pkg;
  localparam int unsigned DW        = 8;
  localparam int unsigned NUM_REGS  = 16;
  localparam int unsigned SUB_FIRST = 1;
  localparam logic [DW-1:0] DEV_WR_ADDR = 8'hDC;

  typedef logic [DW-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK, ST_DATA, ST_DATA_ACK, ST_HOLD
  } wr_state_e;

  // idx = subaddress - SUB_FIRST
  function automatic byte_t reg_default(input int unsigned idx);
    case (idx)
      0, 1, 2, 3, 4, 9, 10, 11: return 8'h80;
      5:  return 8'h01;
      6:  return 8'h09;
      7:  return 8'h04;
      8:  return 8'h10;
      12: return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  function automatic byte_t reg_keep(input int unsigned idx);
    case (idx)
      0, 2, 3, 4: return 8'hFE;
      5:  return 8'h03;
      6:  return 8'h0F;
      8:  return 8'hD7;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic is_level(input int unsigned idx);
    return (idx == 0) || (idx == 2) || (idx == 3) || (idx == 4);
  endfunction

  function automatic byte_t sanitize(input int unsigned idx, input byte_t d);
    byte_t v;
    v = d & reg_keep(idx);
    if (is_level(idx)) begin
      if (v[7:1] == 7'h00)      v = 8'h02;
      else if (v[7:1] == 7'h7F) v = 8'hFC;
    end
    return v;
  endfunction
endpackage

// File: rtl/vpc_i2c_sync.sv
module vpc_i2c_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edge with SCL high on both samples
  assign start_o    = scl_d & scl_o & sda_d & ~sda_o;
  assign stop_o     = scl_d & scl_o & ~sda_d & sda_o;
endmodule

// File: rtl/vpc_i2c_wr_fsm.sv
module vpc_i2c_wr_fsm
  import vpc_cfg_pkg::*;
#(
  parameter byte_t DEV_ADDR = DEV_WR_ADDR
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sda_i,
  input  logic  scl_rise_i,
  input  logic  scl_fall_i,
  input  logic  start_i,
  input  logic  stop_i,
  output logic  sda_oe_o,
  output logic  wr_o,
  output byte_t wr_addr_o,
  output byte_t wr_data_o
);
  localparam int unsigned CNT_W = $clog2(DW + 1);

  wr_state_e        state;
  byte_t            shreg;
  logic [CNT_W-1:0] bit_cnt;
  logic             byte_done;

  assign byte_done = scl_fall_i && (bit_cnt == CNT_W'(DW));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      bit_cnt   <= '0;
      sda_oe_o  <= 1'b0;
      wr_o      <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_o <= 1'b0;
      if (start_i) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_SUB, ST_DATA: begin
            if (scl_rise_i) begin
              shreg   <= {shreg[DW-2:0], sda_i};
              bit_cnt <= bit_cnt + 1'b1;
            end
            if (byte_done) begin
              case (state)
                ST_ADDR: begin
                  if (shreg == DEV_ADDR) begin
                    state    <= ST_ADDR_ACK;
                    sda_oe_o <= 1'b1;
                  end else begin
                    state <= ST_HOLD;
                  end
                end
                ST_SUB: begin
                  wr_addr_o <= shreg;
                  state     <= ST_SUB_ACK;
                  sda_oe_o  <= 1'b1;
                end
                default: begin
                  // commit at the data ACK
                  wr_data_o <= shreg;
                  wr_o      <= 1'b1;
                  state     <= ST_DATA_ACK;
                  sda_oe_o  <= 1'b1;
                end
              endcase
            end
          end
          ST_ADDR_ACK, ST_SUB_ACK, ST_DATA_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              bit_cnt  <= '0;
              state    <= (state == ST_ADDR_ACK) ? ST_SUB :
                          (state == ST_SUB_ACK)  ? ST_DATA : ST_HOLD;
            end
          end
          ST_IDLE, ST_HOLD: ;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/vpc_cfg_regfile.sv
module vpc_cfg_regfile
  import vpc_cfg_pkg::*;
#(
  parameter int unsigned N    = NUM_REGS,
  parameter int unsigned BASE = SUB_FIRST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  byte_t             wr_addr_i,
  input  byte_t             wr_data_i,
  output logic [N-1:0][7:0] regs_o,
  output logic              commit_o
);
  localparam int unsigned LAST = BASE + N - 1;

  byte_t store [N];
  logic  hit;

  assign hit = wr_i && (32'(wr_addr_i) >= BASE) && (32'(wr_addr_i) <= LAST);

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        store[g] <= reg_default(g);
      else if (wr_i && (wr_addr_i == DW'(BASE + g)))
        store[g] <= sanitize(g, wr_data_i);
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) regs_o[i] = store[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) commit_o <= 1'b0;
    else         commit_o <= hit;
  end
endmodule

// File: rtl/vpc_cfg_i2c.sv
module vpc_cfg_i2c
  import vpc_cfg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  output logic            commit_o,
  output logic [6:0]      contrast_o,
  output logic [7:0]      bright_o,
  output logic [2:0][6:0] gain_o,
  output logic [1:0]      bright_range_o,
  output logic [3:0]      osd_level_o,
  output logic            oclamp_sel_o,
  output logic [1:0]      trig_src_o,
  output logic [1:0]      clamp_width_o,
  output logic            trig_edge_o,
  output logic [2:0]      factory_test_o,
  output logic            blk_invert_o,
  output logic            sw_blank_o,
  output logic            ac_mode_o,
  output logic            amp_blank_en_o,
  output logic            amp_standby_o,
  output logic [2:0][7:0] cutoff_o,
  output logic [3:0][7:0] aux_o
);
  localparam int unsigned N_CH      = 3;
  localparam int unsigned N_AUX     = 4;
  localparam int unsigned IX_CRST   = 0;
  localparam int unsigned IX_BRIG   = 1;
  localparam int unsigned IX_GAIN   = 2;
  localparam int unsigned IX_RANGE  = IX_GAIN + N_CH;
  localparam int unsigned IX_OSD    = IX_RANGE + 1;
  localparam int unsigned IX_CLAMP  = IX_OSD + 1;
  localparam int unsigned IX_MODE   = IX_CLAMP + 1;
  localparam int unsigned IX_CUT    = IX_MODE + 1;
  localparam int unsigned IX_AUX    = IX_CUT + N_CH;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr;
  byte_t wr_addr, wr_data;
  logic [NUM_REGS-1:0][7:0] regs;

  vpc_i2c_sync #(.STAGES(2)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  vpc_i2c_wr_fsm #(.DEV_ADDR(DEV_WR_ADDR)) i_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .sda_oe_o,
    .wr_o(wr), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  vpc_cfg_regfile #(.N(NUM_REGS), .BASE(SUB_FIRST)) i_regs (
    .clk_i, .rst_ni, .wr_i(wr), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .regs_o(regs), .commit_o
  );

  assign contrast_o     = regs[IX_CRST][7:1];
  assign bright_o       = regs[IX_BRIG];
  assign bright_range_o = regs[IX_RANGE][1:0];
  assign osd_level_o    = regs[IX_OSD][3:0];
  assign oclamp_sel_o   = regs[IX_CLAMP][7];
  assign trig_src_o     = {regs[IX_CLAMP][4], regs[IX_CLAMP][0]};
  assign clamp_width_o  = regs[IX_CLAMP][3:2];
  assign trig_edge_o    = regs[IX_CLAMP][1];
  assign factory_test_o = {regs[IX_CLAMP][6:5], regs[IX_MODE][4]};
  assign blk_invert_o   = regs[IX_MODE][0];
  assign sw_blank_o     = regs[IX_MODE][1];
  assign ac_mode_o      = regs[IX_MODE][2];
  assign amp_blank_en_o = regs[IX_MODE][6];
  assign amp_standby_o  = regs[IX_MODE][7];

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    assign gain_o[k]   = regs[IX_GAIN + k][7:1];
    assign cutoff_o[k] = regs[IX_CUT + k];
  end

  for (genvar k = 0; k < N_AUX; k++) begin : g_aux
    assign aux_o[k] = regs[IX_AUX + k];
  end

  // reserved storage, always zero
  logic unused_bits;
  assign unused_bits = ^{regs[IX_CRST][0], regs[IX_GAIN][0], regs[IX_GAIN+1][0],
                         regs[IX_GAIN+2][0], regs[IX_RANGE][7:2], regs[IX_OSD][7:4],
                         regs[IX_MODE][5], regs[IX_MODE][3]};
endmodule

// File: rtl/vpc_cfg_i2c_chk.sv
module vpc_cfg_i2c_chk (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_s_i,
  input logic                  start_det_i,
  input logic                  stop_det_i,
  input logic                  sda_oe_i,
  input logic                  commit_i,
  input logic [6:0]            contrast_i,
  input logic [2:0][6:0]       gain_i,
  input logic [15:0][7:0]      regs_i
);
  logic [1:0] commit_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          commit_cnt <= '0;
    else if (start_det_i)                 commit_cnt <= '0;
    else if (commit_i && commit_cnt != 2'd3) commit_cnt <= commit_cnt + 1'b1;
  end

  // R9
  commit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> !commit_i);

  // R3
  single_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_cnt <= 2'd1);

  // R4
  legal_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (contrast_i != 7'h00) && (contrast_i != 7'h7F) &&
    (gain_i[0] != 7'h00) && (gain_i[0] != 7'h7F) &&
    (gain_i[1] != 7'h00) && (gain_i[1] != 7'h7F) &&
    (gain_i[2] != 7'h00) && (gain_i[2] != 7'h7F));

  // R5
  regs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |-> $stable(regs_i));

  // R10
  ack_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !scl_s_i);

  // R10
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i |=> !sda_oe_i);
endmodule

bind vpc_cfg_i2c vpc_cfg_i2c_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .start_det_i(start_det),
  .stop_det_i(stop_det), .sda_oe_i(sda_oe_o), .commit_i(commit_o),
  .contrast_i(contrast_o), .gain_i(gain_o), .regs_i(regs)
);

// File: tb/test_vpc_cfg_i2c.sv
module test_vpc_cfg_i2c;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;

  logic            sda_oe, commit;
  logic [6:0]      contrast;
  logic [7:0]      bright;
  logic [2:0][6:0] gain;
  logic [1:0]      bright_range;
  logic [3:0]      osd_level;
  logic            oclamp_sel;
  logic [1:0]      trig_src;
  logic [1:0]      clamp_width;
  logic            trig_edge;
  logic [2:0]      factory_test;
  logic            blk_invert, sw_blank, ac_mode, amp_blank_en, amp_standby;
  logic [2:0][7:0] cutoff;
  logic [3:0][7:0] aux;

  assign sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  vpc_cfg_i2c i_vpc_cfg_i2c (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .commit_o(commit), .contrast_o(contrast), .bright_o(bright), .gain_o(gain),
    .bright_range_o(bright_range), .osd_level_o(osd_level), .oclamp_sel_o(oclamp_sel),
    .trig_src_o(trig_src), .clamp_width_o(clamp_width), .trig_edge_o(trig_edge),
    .factory_test_o(factory_test), .blk_invert_o(blk_invert), .sw_blank_o(sw_blank),
    .ac_mode_o(ac_mode), .amp_blank_en_o(amp_blank_en), .amp_standby_o(amp_standby),
    .cutoff_o(cutoff), .aux_o(aux)
  );

  int    q_len = 20;
  int    n_cmp = 0;
  int    n_bad = 0;
  int    commit_seen = 0;
  int    exp_commits = 0;
  logic  cmp_en = 1'b0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  logic [7:0] m [1:16];
  logic [113:0] act_vec, exp_vec;

  assign act_vec = {contrast, bright, gain, bright_range, osd_level, oclamp_sel, trig_src,
                    clamp_width, trig_edge, factory_test, blk_invert, sw_blank, ac_mode,
                    amp_blank_en, amp_standby, cutoff, aux, sda_oe, commit};
  assign exp_vec = {m[1][7:1], m[2], m[5][7:1], m[4][7:1], m[3][7:1], m[6][1:0], m[7][3:0],
                    m[8][7], m[8][4], m[8][0], m[8][3:2], m[8][1], m[8][6:5], m[9][4],
                    m[9][0], m[9][1], m[9][2], m[9][6], m[9][7], m[12], m[11], m[10],
                    m[16], m[15], m[14], m[13], 2'b00};

  // per-clock comparison while the bus is quiet
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      n_cmp++;
      if (act_vec !== exp_vec) begin
        n_bad++;
        if (n_bad < 20) $display("FAIL %s outputs act=%h exp=%h", cur_req, act_vec, exp_vec);
      end
    end
  end

  always @(negedge clk) if (commit === 1'b1) commit_seen++;

  task automatic model_reset();
    for (int i = 1; i <= 16; i++) m[i] = 8'h00;
    m[1] = 8'h80; m[2] = 8'h80; m[3] = 8'h80; m[4] = 8'h80; m[5] = 8'h80;
    m[6] = 8'h01; m[7] = 8'h09; m[8] = 8'h04; m[9] = 8'h10;
    m[10] = 8'h80; m[11] = 8'h80; m[12] = 8'h80; m[13] = 8'h08;
  endtask

  task automatic model_write(input int sub, input logic [7:0] d);
    logic [6:0] f;
    logic [7:0] v;
    if (sub < 1 || sub > 16) return;
    case (sub)
      1, 3, 4, 5: begin
        f = d[7:1];
        if (f == 7'd0)   f = 7'd1;
        if (f == 7'd127) f = 7'd126;
        v = {f, 1'b0};
      end
      6: v = {6'b0, d[1:0]};
      7: v = {4'b0, d[3:0]};
      9: begin v = d; v[5] = 1'b0; v[3] = 1'b0; end
      default: v = d;
    endcase
    m[sub] = v;
    exp_commits++;
  endtask

  task automatic check(input bit ok, input string req, input string what, input int a, input int e);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, a, e);
    end
  endtask

  task automatic hold(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(q_len);
    scl_m = 1'b1; hold(q_len);
    sda_m = 1'b0; hold(q_len);
    scl_m = 1'b0; hold(q_len);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(q_len);
    scl_m = 1'b1; hold(q_len);
    sda_m = 1'b1; hold(q_len);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    hold(q_len);
    scl_m = 1'b1; hold(2 * q_len);
    scl_m = 1'b0; hold(q_len);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit got;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; hold(q_len);
    scl_m = 1'b1; hold(q_len);
    got = (sda_bus === 1'b0);
    hold(q_len);
    scl_m = 1'b0; hold(q_len);
    check(got == exp_ack, req, $sformatf("ack after byte %02h", b), int'(got), int'(exp_ack));
  endtask

  task automatic settle(input string req);
    hold(8);
    check(commit_seen == exp_commits, req, "commit count", commit_seen, exp_commits);
    cur_req = req;
    cmp_en = 1'b1;
    hold(16);
    cmp_en = 1'b0;
  endtask

  task automatic write_reg(input logic [7:0] sub, input logic [7:0] data, input string req);
    bus_start();
    send_byte(8'hDC, 1'b1, req);
    send_byte(sub, 1'b1, req);
    send_byte(data, 1'b1, req);
    bus_stop();
    model_write(int'(sub), data);
    settle(req);
  endtask

  initial begin
    model_reset();
    hold(5);
    rst_n = 1'b1;
    settle("R1");

    // R4 level fields and clamping
    write_reg(8'h01, 8'hAA, "R4");
    write_reg(8'h03, 8'h00, "R4");
    write_reg(8'h04, 8'hFF, "R4");
    write_reg(8'h05, 8'h01, "R4");
    write_reg(8'h05, 8'hFE, "R4");
    write_reg(8'h01, 8'h02, "R4");

    // R6 / R7 field positions
    write_reg(8'h08, 8'hA5, "R6");
    write_reg(8'h08, 8'h5A, "R6");
    write_reg(8'h09, 8'hFF, "R7");
    write_reg(8'h09, 8'h2C, "R7");

    // R5 reserved masking, other registers untouched
    write_reg(8'h06, 8'hFE, "R5");
    write_reg(8'h07, 8'hF6, "R5");
    write_reg(8'h0A, 8'h3C, "R5");
    write_reg(8'h10, 8'hC3, "R5");
    write_reg(8'h0D, 8'h5A, "R9");

    // R2 address filtering
    bus_start();
    send_byte(8'hDD, 1'b0, "R2");
    send_byte(8'h02, 1'b0, "R2");
    send_byte(8'h55, 1'b0, "R2");
    bus_stop();
    settle("R2");
    bus_start();
    send_byte(8'h6E, 1'b0, "R2");
    send_byte(8'h02, 1'b0, "R2");
    send_byte(8'h11, 1'b0, "R2");
    bus_stop();
    settle("R2");

    // R8 unused subaddresses
    write_reg(8'h00, 8'h77, "R8");
    write_reg(8'h11, 8'h77, "R8");
    write_reg(8'hFF, 8'h77, "R8");

    // R3 extra data bytes ignored
    bus_start();
    send_byte(8'hDC, 1'b1, "R3");
    send_byte(8'h0B, 1'b1, "R3");
    send_byte(8'h11, 1'b1, "R3");
    send_byte(8'h22, 1'b0, "R3");
    send_byte(8'h33, 1'b0, "R3");
    bus_stop();
    model_write(8'h0B, 8'h11);
    settle("R3");

    // R10 repeated START restarts decoding
    bus_start();
    send_byte(8'hDC, 1'b1, "R10");
    send_byte(8'h02, 1'b1, "R10");
    bus_start();
    send_byte(8'hDC, 1'b1, "R10");
    send_byte(8'h02, 1'b1, "R10");
    send_byte(8'h33, 1'b1, "R10");
    bus_stop();
    model_write(8'h02, 8'h33);
    settle("R10");

    // R11 slow (200 kHz) and fast SCL
    q_len = 125;
    write_reg(8'h0C, 8'h9C, "R11");
    q_len = 4;
    write_reg(8'h0E, 8'h3E, "R11");
    write_reg(8'h03, 8'h7F, "R11");
    q_len = 20;

    // R1 reset restores defaults
    rst_n = 1'b0;
    hold(3);
    rst_n = 1'b1;
    model_reset();
    settle("R1");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R11 watchdog act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule